// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is the watchdog of a small microcontroller. A main counter advances on every enabled clock. When it reaches the period picked by a two-bit select, the block raises a time-out flag and shows it as an interrupt. The interrupt is meant to wake the CPU from idle, or to let software service the watchdog.

Setting the flag also starts a fixed grace countdown. If software restarts the watchdog before the grace window closes, nothing further happens. If it does not, the block emits a one-cycle system reset pulse and starts over from zero.

A clock-enable input models the clock tree. The watchdog keeps counting while the CPU idles. When the clock-enable is low, as in power-down, every part of the block freezes. Register decode and interrupt routing sit outside this block.

Top module: `wdog_twostage`

## Requirements
- R1: An active-low `rst_n` clears the whole block at once. While it is low and right after it is released, `irq` and `wd_rst` are 0 and both counters start again from zero.
- R2: With `tick_en`, `wd_en` and `irq_en` high and no restart, `irq` rises exactly 2^(TAP_BASE + TAP_STEP*`tsel`) clocks after counting starts. `tsel` = 0 selects the shortest period and 3 the longest (16, 64, 256 and 1024 clocks with the defaults).
- R3: A `kick` in a cycle with `tick_en` high clears the main counter, the grace counter and the time-out flag on that edge. The next time-out is then counted from zero.
- R4: `irq` is the time-out flag ANDed with `irq_en`. With `irq_en` low the flag still sets and the grace countdown still runs. Raising `irq_en` while the flag is set makes `irq` high at once.
- R5: With no restart, `wd_rst` is high for exactly one clock, GRACE enabled clocks after the flag set (512 by default). On that same edge the flag and both counters clear.
- R6: While `wd_en` is low (with `tick_en` high), the counters and the flag are held clear. No interrupt and no reset occur.
- R7: While `tick_en` is low, all state holds and `kick` is ignored. Counting resumes from the held value once `tick_en` returns.
- R8: If `tsel` is lowered so that the main count already lies at or beyond the new period, the time-out fires on the next enabled clock.
- R9: A `kick` during the grace window cancels the pending reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tick_en | input | 1 | Clock enable; low freezes the block (power-down) |
| wd_en | input | 1 | Watchdog enable |
| irq_en | input | 1 | Time-out interrupt enable |
| kick | input | 1 | Software restart strobe |
| tsel | input | 2 | Time-out period select |
| irq | output | 1 | Time-out interrupt request |
| wd_rst | output | 1 | One-cycle system reset request |

## Verification
The bench measures the time-out cycle for every select value. An off-by-one tap or compare would show up there as an interrupt one clock early or late. It also times the grace window to the exact cycle and checks that the reset pulse is one clock wide and leaves the block cleared. A design that forgot to clear would pulse again or hold `irq` high.

Directed cases cover the following:
- A restart in mid-window, which a broken design would not honour.
- A clock-enable gap with restarts inside it, which a leaky design would act on.
- A shrink of the select below the running count, which an equality-only compare would miss until the counter wrapped.
- A masked interrupt that must still lead to a reset.

Random stimulus then runs against a cycle model in the bench.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
    localparam int WD_TSEL_W   = 2;
    localparam int WD_NUM_TAPS = 1 << WD_TSEL_W;

    // Exponent of the period selected by tap index sel.
    function automatic int tap_exp(input int base, input int step, input int sel);
        return base + step * sel;
    endfunction
endpackage

// File: rtl/wdog_tap_cmp.sv
`timescale 1ns/1ps
module wdog_tap_cmp
    import wdog_pkg::*;
#(
    parameter int TAP_BASE = 4,
    parameter int TAP_STEP = 2,
    parameter int CNT_W    = TAP_BASE + TAP_STEP * (WD_NUM_TAPS - 1)
) (
    input  logic [CNT_W-1:0]     cnt,
    input  logic [WD_TSEL_W-1:0] tsel,
    output logic                 expired
);
    logic [WD_NUM_TAPS-1:0] hit;

    // One comparator per tap. ">=" lets a shrunk period expire at once.
    for (genvar i = 0; i < WD_NUM_TAPS; i++) begin : g_tap
        localparam logic [CNT_W-1:0] LAST =
            CNT_W'((64'd1 << tap_exp(TAP_BASE, TAP_STEP, i)) - 64'd1);
        assign hit[i] = (cnt >= LAST);
    end

    assign expired = hit[tsel];
endmodule

// File: rtl/wdog_grace_cmp.sv
`timescale 1ns/1ps
module wdog_grace_cmp #(
    parameter int GRACE = 512,
    parameter int GR_W  = (GRACE > 1) ? $clog2(GRACE) : 1
) (
    input  logic [GR_W-1:0] cnt,
    output logic            done
);
    localparam logic [GR_W-1:0] GR_LAST = GR_W'(GRACE - 1);

    assign done = (cnt == GR_LAST);
endmodule

// File: rtl/wdog_twostage.sv
`timescale 1ns/1ps
module wdog_twostage
    import wdog_pkg::*;
#(
    parameter int TAP_BASE = 4,
    parameter int TAP_STEP = 2,
    parameter int GRACE    = 512
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 wd_en,
    input  logic                 irq_en,
    input  logic                 kick,
    input  logic [WD_TSEL_W-1:0] tsel,
    output logic                 irq,
    output logic                 wd_rst
);
    localparam int CNT_W = TAP_BASE + TAP_STEP * (WD_NUM_TAPS - 1);
    localparam int GR_W  = (GRACE > 1) ? $clog2(GRACE) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [GR_W-1:0]  grace;
        logic             flag;
        logic             rst;
    } wd_state_t;

    wd_state_t s_d, s_q;
    logic      expired;
    logic      grace_done;

    wdog_tap_cmp #(
        .TAP_BASE (TAP_BASE),
        .TAP_STEP (TAP_STEP),
        .CNT_W    (CNT_W)
    ) u_tap (
        .cnt     (s_q.cnt),
        .tsel    (tsel),
        .expired (expired)
    );

    wdog_grace_cmp #(
        .GRACE (GRACE),
        .GR_W  (GR_W)
    ) u_grace (
        .cnt  (s_q.grace),
        .done (grace_done)
    );

    always_comb begin
        s_d     = s_q;
        s_d.rst = 1'b0;
        if (tick_en) begin
            if (kick || !wd_en) begin
                s_d.cnt   = '0;
                s_d.grace = '0;
                s_d.flag  = 1'b0;
            end else if (!s_q.flag) begin
                if (expired) begin
                    s_d.flag  = 1'b1;
                    s_d.cnt   = '0;
                    s_d.grace = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end else if (grace_done) begin
                s_d.rst   = 1'b1;
                s_d.flag  = 1'b0;
                s_d.cnt   = '0;
                s_d.grace = '0;
            end else begin
                s_d.grace = s_q.grace + GR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq    = s_q.flag & irq_en;
    assign wd_rst = s_q.rst;
endmodule

// File: rtl/wdog_twostage_chk.sv
`timescale 1ns/1ps
module wdog_twostage_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             wd_en,
    input logic             kick,
    input logic             irq,
    input logic             wd_rst,
    input logic             flag_q,
    input logic [CNT_W-1:0] cnt_q
);
    // R3: a restart clears the counter and the flag on the next edge
    a_r3_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && kick) |=> (cnt_q == '0 && !flag_q && !irq));

    // R5: the reset pulse lasts one clock
    a_r5_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst |=> !wd_rst);

    // R5: the reset follows a set flag and clears it
    a_r5_rst_after_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst |-> ($past(flag_q) && !flag_q));

    // R6: a disabled watchdog stays quiet
    a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wd_en) |=> (!flag_q && !wd_rst));

    // R7: without clock enable all state holds
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(cnt_q) && $stable(flag_q) && !wd_rst));
endmodule

bind wdog_twostage wdog_twostage_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wd_en   (wd_en),
    .kick    (kick),
    .irq     (irq),
    .wd_rst  (wd_rst),
    .flag_q  (s_q.flag),
    .cnt_q   (s_q.cnt)
);

// File: tb/wdog_twostage_bench.sv
`timescale 1ns/1ps
module wdog_twostage_bench;
    localparam int TB_BASE  = 4;
    localparam int TB_STEP  = 2;
    localparam int TB_GRACE = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wd_en = 1'b0;
    logic       irq_en = 1'b0;
    logic       kick = 1'b0;
    logic [1:0] tsel = 2'd0;
    logic       irq;
    logic       wd_rst;

    int    vectors = 0;
    int    fails   = 0;
    string cur_req = "R1";
    bit    done    = 1'b0;

    // bench-side model state
    int m_cnt = 0, m_grace = 0;
    bit m_flag = 1'b0, m_rst = 1'b0;

    always #10 clk = ~clk;

    wdog_twostage #(.TAP_BASE(TB_BASE), .TAP_STEP(TB_STEP), .GRACE(TB_GRACE)) u_wdog_twostage (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wd_en(wd_en), .irq_en(irq_en),
        .kick(kick), .tsel(tsel), .irq(irq), .wd_rst(wd_rst)
    );

    function automatic int period(input int sel);
        return 1 << (TB_BASE + TB_STEP * sel);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_update();
        m_rst = 1'b0;
        if (!rst_n) begin
            m_cnt = 0; m_grace = 0; m_flag = 1'b0;
        end else if (tick_en) begin
            if (kick || !wd_en) begin
                m_cnt = 0; m_grace = 0; m_flag = 1'b0;
            end else if (!m_flag) begin
                if (m_cnt >= period(int'(tsel)) - 1) begin
                    m_flag = 1'b1; m_cnt = 0; m_grace = 0;
                end else m_cnt++;
            end else if (m_grace == TB_GRACE - 1) begin
                m_rst = 1'b1; m_flag = 1'b0; m_cnt = 0; m_grace = 0;
            end else m_grace++;
        end
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check({cur_req, " irq"}, int'(irq), int'(m_flag & irq_en));
        check({cur_req, " wd_rst"}, int'(wd_rst), int'(m_rst));
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic cycles_to_irq(input int max, output int n);
        n = 0;
        do begin step(); n++; end while (!irq && n < max);
    endtask

    task automatic cycles_to_rst(input int max, output int n);
        n = 0;
        do begin step(); n++; end while (!wd_rst && n < max);
    endtask

    task automatic do_kick();
        kick = 1'b1; step(); kick = 1'b0;
    endtask

    initial begin
        int n;
        bit seen;
        void'($urandom(32'd20240611));

        // R1: reset state
        cur_req = "R1";
        steps(3);
        check("R1 irq in reset", int'(irq), 0);
        check("R1 wd_rst in reset", int'(wd_rst), 0);
        rst_n = 1'b1; tick_en = 1'b1; wd_en = 1'b1; irq_en = 1'b1;

        // R2: period per select value
        cur_req = "R2";
        for (int t = 0; t < 4; t++) begin
            tsel = 2'(t);
            do_kick();
            cycles_to_irq(5000, n);
            check("R2 time-out cycles", n, period(t));
        end

        // R5: grace window, single pulse, block cleared after
        cur_req = "R5";
        tsel = 2'd0;
        do_kick();
        cycles_to_irq(100, n);
        cycles_to_rst(2000, n);
        check("R5 grace cycles", n, TB_GRACE);
        step();
        check("R5 pulse width", int'(wd_rst), 0);
        check("R5 flag cleared", int'(irq), 0);
        cycles_to_irq(100, n);
        check("R5 fresh period after reset", n, period(0) - 1);

        // R4: masked interrupt still leads to reset
        cur_req = "R4";
        irq_en = 1'b0;
        do_kick();
        steps(period(0));
        check("R4 irq masked", int'(irq), 0);
        irq_en = 1'b1; #1;
        check("R4 flag visible on unmask", int'(irq), 1);
        irq_en = 1'b0;
        cycles_to_rst(2000, n);
        check("R4 reset with irq masked", n, TB_GRACE);
        irq_en = 1'b1;

        // R9: restart inside the grace window
        cur_req = "R9";
        tsel = 2'd0;
        do_kick();
        cycles_to_irq(100, n);
        steps(300);
        tsel = 2'd3;
        do_kick();
        seen = 1'b0;
        for (int i = 0; i < 600; i++) begin step(); if (wd_rst) seen = 1'b1; end
        check("R9 reset cancelled", int'(seen), 0);
        check("R3 flag cleared by kick", int'(irq), 0);

        // R6: disabled
        cur_req = "R6";
        tsel = 2'd0; wd_en = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 1200; i++) begin step(); if (irq || wd_rst) seen = 1'b1; end
        check("R6 quiet while off", int'(seen), 0);
        wd_en = 1'b1;

        // R7: clock enable low freezes and ignores kick
        cur_req = "R7";
        do_kick();
        steps(10);
        tick_en = 1'b0;
        for (int i = 0; i < 100; i++) begin kick = (i % 7 == 0); step(); end
        kick = 1'b0;
        check("R7 no irq while frozen", int'(irq), 0);
        tick_en = 1'b1;
        cycles_to_irq(100, n);
        check("R7 resume from held count", n, period(0) - 10);

        // R8: select shrunk below running count
        cur_req = "R8";
        tsel = 2'd3;
        do_kick();
        steps(100);
        tsel = 2'd0;
        step();
        check("R8 immediate time-out", int'(irq), 1);

        // R1: reset during grace
        cur_req = "R1";
        steps(50);
        rst_n = 1'b0; #1;
        check("R1 async clear", int'(irq), 0);
        step();
        rst_n = 1'b1;
        cycles_to_irq(100, n);
        check("R1 fresh count after reset", n, period(0));

        // random mix, compared to the model every clock (R2..R9)
        cur_req = "R3 random";
        for (int i = 0; i < 6000; i++) begin
            tick_en = ($urandom_range(0, 9) != 0);
            wd_en   = ($urandom_range(0, 49) != 0);
            irq_en  = ($urandom_range(0, 3) != 0);
            kick    = ($urandom_range(0, 199) == 0);
            if ($urandom_range(0, 99) == 0) tsel = 2'($urandom_range(0, 3));
            step();
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule